// File: doc/BRIEF.md
# Peripheral Interrupt Merger with Read-to-Acknowledge Flags

This block gathers single-cycle event pulses from motor-control peripherals and folds them into one active-low interrupt request for the processor core. It keeps three sticky flag registers. The first holds a PWM trip flag and a PWM sync flag. The other two each hold one flag per pin of an 8-pin port. Each flag is set by its event and stays set until software reads the register that holds it. That read returns the flags and clears them in the same access, so the read is the acknowledgement.

A small enable register controls whether trip and sync events may set their flags. Port-pin events are always recorded. The request line is a level, not a pulse. It stays low for as long as any flag in any register is pending, so a core that samples it by level loses no event while earlier ones wait to be served. If an event arrives in the same cycle as the read that clears its register, the new flag survives the clear.

The bus is a plain strobe interface. Read data comes back combinationally during the read strobe, and the clear takes effect at the clock edge that ends the read.

Top module: `periph_irq_merge`

## Requirements
- R1: After reset, every flag and both enable bits read as 0, and irq_n is 1.
- R2: A trip_evt pulse while enable bit 0 is 1 sets bit 0 of the peripheral flag register (address 0). A sync_evt pulse while enable bit 1 is 1 sets bit 1 of that register. Each flag is set at the clock edge where its pulse is sampled.
- R3: A trip_evt pulse while enable bit 0 is 0 leaves flag bit 0 unchanged. A sync_evt pulse while enable bit 1 is 0 leaves flag bit 1 unchanged.
- R4: A pulse on pin_evt bit p*8+i sets bit i of the port flag register at address 1+p (p = 0 or 1). That bit stays set until the register is read.
- R5: irq_n is 0 in every cycle in which at least one flag bit in any of the three registers is set, and 1 otherwise.
- R6: A read of address 0 returns the trip flag on bit 0 and the sync flag on bit 1, with 0 on every other bit, and clears both flags at the clock edge that ends the read.
- R7: A read of a port flag register returns its 8 bits and clears all of them. Flags held in the other registers are not affected.
- R8: An event whose flag belongs to a register being read in the same cycle leaves that flag set after the clear.
- R9: The enable register at address 3 is written with bits [1:0] of bus_wdata and reads back on bits [1:0]. Reading it clears nothing. Writes to addresses 0 to 2 change no flag.
- R10: With flags pending in several registers, irq_n stays 0 until every one of those registers has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_evt | input | 1 | PWM trip event pulse |
| sync_evt | input | 1 | PWM sync event pulse |
| pin_evt | input | 16 | Port-pin event pulses, port 0 in [7:0], port 1 in [15:8] |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; clears the addressed flag register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_n | output | 1 | Merged active-low interrupt request |

## Verification
The assertions check on every cycle that:
- an enabled trip event always lands in its flag, and that flag survives a clearing read in the same cycle;
- a disabled source never raises its flag;
- a read of the peripheral register with no new event leaves it empty;
- pending flags hold the request low;
- the request cannot return high without a read.

Only the bench's scenarios can show:
- the values returned on the read bus;
- that a read of one port register leaves the other registers alone;
- that the line is released only after the last of several registers is read;
- that enables written over the bus take effect on later events.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // Bit positions inside the peripheral flag register and the enable register
   localparam int TRIP_BIT = 0;
   localparam int SYNC_BIT = 1;
   localparam int PER_W    = 2;

   // Address of the peripheral flag register
   localparam int PER_ADDR = 0;

   // Port p lives directly above the peripheral flag register
   function automatic int port_addr(input int p);
      return p + 1;
   endfunction
endpackage

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] q
);
   logic [W-1:0] kept;

   // a clearing read drops old bits, same-cycle sets always win
   assign kept = clr ? '0 : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= kept | set;
   end
endmodule

// File: rtl/pirq_enable_reg.sv
module pirq_enable_reg #(
   parameter int DATA_W = 8,
   parameter int EN_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [EN_W-1:0]   en
);
   logic unused_hi;

   if (DATA_W > EN_W) begin : g_hi
      assign unused_hi = ^wdata[DATA_W-1:EN_W];
   end else begin : g_nohi
      assign unused_hi = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en <= '0;
      else if (wr) en <= wdata[EN_W-1:0];
   end
endmodule

// File: rtl/pirq_rd_mux.sv
module pirq_rd_mux
   import pirq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 2
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        rd,
   input  logic [PER_W-1:0]            per_q,
   input  logic [NUM_PORTS*PORT_W-1:0] port_q,
   input  logic [PER_W-1:0]            en_q,
   output logic [DATA_W-1:0]           rdata
);
   localparam logic [ADDR_W-1:0] EN_A  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(PER_ADDR);

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == PER_A) rdata[PER_W-1:0] = per_q;
         if (addr == EN_A)  rdata[PER_W-1:0] = en_q;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(port_addr(p)))
               rdata[PORT_W-1:0] = port_q[p*PORT_W +: PORT_W];
         end
      end
   end
endmodule

// File: rtl/periph_irq_merge.sv
module periph_irq_merge
   import pirq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 2,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        trip_evt,
   input  logic                        sync_evt,
   input  logic [NUM_PORTS*PORT_W-1:0] pin_evt,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_rd,
   input  logic                        bus_wr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        irq_n
);
   localparam logic [ADDR_W-1:0] EN_A  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(PER_ADDR);
   localparam int                ALL_W = PER_W + NUM_PORTS * PORT_W;

   // elaboration checks on the parameter set
   if (DATA_W < PORT_W || DATA_W < PER_W) begin : g_bad_width
      $error("periph_irq_merge: DATA_W must cover PORT_W and the peripheral flags");
   end
   if (NUM_PORTS < 1 || NUM_PORTS + 2 > (1 << ADDR_W)) begin : g_bad_map
      $error("periph_irq_merge: address space cannot hold the port registers");
   end

   logic [PER_W-1:0]            per_q;
   logic [PER_W-1:0]            per_set;
   logic [PER_W-1:0]            en_q;
   logic [NUM_PORTS*PORT_W-1:0] port_q;
   logic                        any_flag;

   // enable register
   pirq_enable_reg #(.DATA_W(DATA_W), .EN_W(PER_W)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr && bus_addr == EN_A),
      .wdata (bus_wdata),
      .en    (en_q)
   );

   // peripheral flags, gated by their enables
   always_comb begin
      per_set           = '0;
      per_set[TRIP_BIT] = trip_evt && en_q[TRIP_BIT];
      per_set[SYNC_BIT] = sync_evt && en_q[SYNC_BIT];
   end

   pirq_flag_bank #(.W(PER_W)) u_per (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (per_set),
      .clr   (bus_rd && bus_addr == PER_A),
      .q     (per_q)
   );

   // one flag bank per port
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] PA = ADDR_W'(port_addr(p));
      pirq_flag_bank #(.W(PORT_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (pin_evt[p*PORT_W +: PORT_W]),
         .clr   (bus_rd && bus_addr == PA),
         .q     (port_q[p*PORT_W +: PORT_W])
      );
   end

   pirq_rd_mux #(
      .DATA_W(DATA_W), .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)
   ) u_mux (
      .addr   (bus_addr),
      .rd     (bus_rd),
      .per_q  (per_q),
      .port_q (port_q),
      .en_q   (en_q),
      .rdata  (bus_rdata)
   );

   logic [ALL_W-1:0] all_flags;
   assign all_flags = {port_q, per_q};
   assign any_flag  = |all_flags;

   // request output: direct level or one retiming register
   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~any_flag;
      end
      assign irq_n = irq_q;
   end else begin : g_irq_comb
      assign irq_n = ~any_flag;
   end
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 2,
   parameter bit IRQ_REG   = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        trip_evt,
   input logic                        sync_evt,
   input logic                        bus_rd,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [1:0]                  per_q,
   input logic [1:0]                  en_q,
   input logic [NUM_PORTS*PORT_W-1:0] port_q,
   input logic                        irq_n
);
   // R2
   trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_evt && en_q[0]) |=> per_q[0]);

   // R3
   trip_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[0] && !per_q[0]) |=> !per_q[0]);

   // R3
   sync_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[1] && !per_q[1]) |=> !per_q[1]);

   // R6
   per_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0 && !trip_evt && !sync_evt) |=> (per_q == 2'b00));

   // R8
   clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == '0 && sync_evt && en_q[1]) |=> per_q[1]);

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !bus_rd) |=> !irq_n);

   if (!IRQ_REG) begin : g_lvl
      // R5
      irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|{port_q, per_q}) |-> !irq_n);
   end
endmodule

bind periph_irq_merge pirq_chk #(
   .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trip_evt (trip_evt),
   .sync_evt (sync_evt),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .per_q    (per_q),
   .en_q     (en_q),
   .port_q   (port_q),
   .irq_n    (irq_n)
);

// File: tb/tb_periph_irq_merge.sv
module tb_periph_irq_merge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trip_evt = 1'b0, sync_evt = 1'b0;
   logic [15:0] pin_evt = '0;
   logic [1:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [1:0]  m_per = '0;
   logic [1:0]  m_en  = '0;
   logic [15:0] m_port = '0;

   periph_irq_merge dut (
      .clk(clk), .rst_n(rst_n), .trip_evt(trip_evt), .sync_evt(sync_evt),
      .pin_evt(pin_evt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rdata(input logic [1:0] a);
      case (a)
         2'd0: return {6'b0, m_per};
         2'd1: return m_port[7:0];
         2'd2: return m_port[15:8];
         default: return {6'b0, m_en};
      endcase
   endfunction

   // one bus cycle: drive at negedge, check, then advance the reference model
   task automatic step(input string tag, input logic t, input logic s, input logic [15:0] pins,
                       input logic rd, input logic wr, input logic [1:0] a, input logic [7:0] wd);
      @(negedge clk);
      trip_evt = t; sync_evt = s; pin_evt = pins;
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      #1;
      check("R5", {15'b0, irq_n}, {15'b0, ~|{m_port, m_per}});
      if (rd) check(tag, {8'b0, bus_rdata}, {8'b0, exp_rdata(a)});
      // next-state of the reference
      if (rd && a == 2'd0) m_per = '0;
      if (rd && a == 2'd1) m_port[7:0] = '0;
      if (rd && a == 2'd2) m_port[15:8] = '0;
      m_per[0] = m_per[0] | (t & m_en[0]);
      m_per[1] = m_per[1] | (s & m_en[1]);
      m_port   = m_port | pins;
      if (wr && a == 2'd3) m_en = wd[1:0];
   endtask

   task automatic idle();
      step("R5", 0, 0, '0, 0, 0, 2'd0, 8'h00);
   endtask

   initial begin : main
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      #23 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1", {15'b0, irq_n}, 16'h0001);
      step("R1", 0, 0, '0, 1, 0, 2'd0, 0);
      step("R1", 0, 0, '0, 1, 0, 2'd3, 0);
      step("R1", 0, 0, '0, 1, 0, 2'd1, 0);
      step("R1", 0, 0, '0, 1, 0, 2'd2, 0);

      // R3 disabled sources do not flag
      step("R3", 1, 1, '0, 0, 0, 2'd0, 0);
      idle();
      check("R3", {15'b0, irq_n}, 16'h0001);
      step("R3", 0, 0, '0, 1, 0, 2'd0, 0);

      // R9 enable write; writes to flag addresses ignored
      step("R9", 0, 0, '0, 0, 1, 2'd3, 8'hFF);
      step("R9", 0, 0, '0, 1, 0, 2'd3, 0);
      step("R9", 0, 0, '0, 0, 1, 2'd1, 8'hFF);
      step("R9", 0, 0, '0, 1, 0, 2'd1, 0);

      // R2 enabled sources flag
      step("R2", 1, 0, '0, 0, 0, 2'd0, 0);
      step("R2", 0, 1, '0, 0, 0, 2'd0, 0);
      step("R6", 0, 0, '0, 1, 0, 2'd0, 0);
      step("R6", 0, 0, '0, 1, 0, 2'd0, 0);

      // R8 event during clearing read
      step("R8", 1, 0, '0, 0, 0, 2'd0, 0);
      step("R8", 0, 1, '0, 1, 0, 2'd0, 0);
      step("R8", 0, 0, '0, 1, 0, 2'd0, 0);
      step("R8", 0, 0, 16'h0100, 1, 0, 2'd2, 0);
      step("R8", 0, 0, '0, 1, 0, 2'd2, 0);

      // R4/R7/R10 flags in all registers; release only after last read
      step("R4", 1, 0, 16'h8001, 0, 0, 2'd0, 0);
      step("R4", 0, 0, 16'h0240, 0, 0, 2'd0, 0);
      step("R7", 0, 0, '0, 1, 0, 2'd1, 0);
      check("R10", {15'b0, irq_n}, 16'h0000);
      step("R7", 0, 0, '0, 1, 0, 2'd0, 0);
      check("R10", {15'b0, irq_n}, 16'h0000);
      step("R7", 0, 0, '0, 1, 0, 2'd2, 0);
      idle();
      check("R10", {15'b0, irq_n}, 16'h0001);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic t, s, rd, wr;
         logic [15:0] pins;
         logic [1:0] a;
         t  = ($urandom % 10) == 0;
         s  = ($urandom % 10) == 0;
         pins = (($urandom % 6) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
         rd = ($urandom % 5) == 0;
         wr = ($urandom % 25) == 0;
         a  = 2'($urandom);
         step(a == 2'd0 ? "R6" : (a == 2'd3 ? "R9" : "R7"), t, s, pins, rd, wr, a, 8'($urandom));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      #1500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule